// File: doc/BRIEF.md
# Pixel De-Knee and Gain Stage

This block sits at the head of a camera pixel pipeline and accepts one 10-bit sensor sample per clock, qualified by a valid flag. The front end ahead of it may have squeezed bright signal above a chosen knee point with a slope of one half. This stage restores that range first. It then removes the black pedestal and scales the result by a programmable digital gain. The output is a 10-bit sample that saturates at both ends, with a valid flag delayed to match.

Three settings control the stage: the knee point, the gain and an optional replacement for the black level. When the replacement is off, the nominal pedestal of 48 codes is removed. The settings are taken in only on a frame-start pulse, so a frame is never processed with a mix of old and new values. Each pipeline stage picks up its setting one cycle after the stage before it, so pixels already in flight when the pulse arrives finish with the values they started with.

Top module: `pix_deknee_gain`

## Requirements
- R1: During and after reset, `out_valid` and `out_pix` are 0. The active settings reset to: knee 1023 (no expansion), black level 48, gain 1.0.
- R2: `out_valid` equals `in_valid` from exactly 3 clocks earlier. The sample that matches it appears on `out_pix` in the same cycle.
- R3: Let k be the active knee. A sample p with p > k becomes k + 2*(p - k). A sample p <= k passes through unchanged.
- R4: When `cfg_black_ovr` was 0 at the last capture, 48 is subtracted from the expanded sample.
- R5: When `cfg_black_ovr` was 1 at the last capture, `cfg_black` is subtracted in place of 48.
- R6: Gain is unsigned, with 4 integer bits (bits 7:4) and 4 fractional bits (bits 3:0). The output is floor(v * gain / 16), where v is the sample after black subtraction.
- R7: Any gain code below 0x10 (1.0) is applied as 0x10.
- R8: If the black level is larger than the expanded sample, the result is 0. It never wraps.
- R9: Any result above 1023, whether from knee expansion or from gain, is clipped to 1023.
- R10: Changes on the `cfg_*` inputs have no effect on the output until `frame_start` is sampled high.
- R11: A sample presented in the same cycle as `frame_start` is still processed with the previous settings. Samples presented in the following cycles use the new settings, even when they run back-to-back with it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | Captures the configuration inputs |
| cfg_knee | input | 10 | Knee point |
| cfg_gain | input | 8 | Gain, unsigned 4.4 |
| cfg_black_ovr | input | 1 | 1 = use cfg_black, 0 = use 48 |
| cfg_black | input | 10 | Replacement black level |
| in_valid | input | 1 | Input sample valid |
| in_pix | input | 10 | Input sample |
| out_valid | output | 1 | Output sample valid |
| out_pix | output | 10 | Processed, saturated sample |

## Verification
The bench probes samples exactly at the knee and one code above it. A strict-versus-inclusive comparison error would show there as a value off by one. It also drives samples at, just above and below the black level, where a design without a floor would wrap to a large code instead of giving 0. Large gain settings and a knee of zero push results past full scale, so a missing clip shows up as a wrapped low value. Gain codes below unity would darken the picture if they were not clamped. One test runs a sample in the frame-start cycle back-to-back with one just after it. A design that moved all settings to every stage at the same moment would give the first sample the new gain.

// File: rtl/pdg_pkg.sv
// Shared defaults for the pixel de-knee and gain stage.
// Assumes: all modules take these as parameter defaults only.
package pdg_pkg;
    localparam int PDG_PIX_W     = 10;  // sample width
    localparam int PDG_GAIN_W    = 8;   // gain code width
    localparam int PDG_GAIN_FRAC = 4;   // fractional gain bits
    localparam int PDG_BLACK_NOM = 48;  // nominal black pedestal
    localparam int PDG_LATENCY   = 3;   // pipeline depth in clocks
endpackage

// File: rtl/pdg_cfg_stage.sv
// Configuration capture with per-stage hand-off.
// Takes in the cfg inputs on frame_start, then releases the knee to stage 1
// right away, the black level to stage 2 one clock later and the gain to
// stage 3 two clocks later. The result is that each pixel sees one consistent set.
// Assumes: frame_start is a single-cycle pulse in the clk domain.
module pdg_cfg_stage #(
    parameter int PIX_W     = pdg_pkg::PDG_PIX_W,
    parameter int GAIN_W    = pdg_pkg::PDG_GAIN_W,
    parameter int GAIN_FRAC = pdg_pkg::PDG_GAIN_FRAC,
    parameter int BLACK_NOM = pdg_pkg::PDG_BLACK_NOM
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic [PIX_W-1:0]  cfg_knee,
    input  logic [GAIN_W-1:0] cfg_gain,
    input  logic              cfg_black_ovr,
    input  logic [PIX_W-1:0]  cfg_black,
    output logic [PIX_W-1:0]  knee_s1,
    output logic [PIX_W-1:0]  black_s2,
    output logic [GAIN_W-1:0] gain_s3
);
    localparam logic [GAIN_W-1:0] GAIN_ONE  = GAIN_W'(1 << GAIN_FRAC);
    localparam logic [PIX_W-1:0]  BLACK_DEF = PIX_W'(BLACK_NOM);
    localparam logic [PIX_W-1:0]  KNEE_DEF  = '1;

    logic [PIX_W-1:0]  cap_black;
    logic [GAIN_W-1:0] cap_gain;
    logic [GAIN_W-1:0] gain_clamped;
    logic [PIX_W-1:0]  black_sel;
    logic [2:1]        fs_d;

    // Raise sub-unity gain codes to 1.0 and choose the black source.
    always_comb begin
        gain_clamped = (cfg_gain < GAIN_ONE) ? GAIN_ONE : cfg_gain;
        black_sel    = cfg_black_ovr ? cfg_black : BLACK_DEF;
    end

    // Capture every setting on the frame-start pulse; the knee feeds stage 1 directly.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            knee_s1   <= KNEE_DEF;
            cap_black <= BLACK_DEF;
            cap_gain  <= GAIN_ONE;
        end else if (frame_start) begin
            knee_s1   <= cfg_knee;
            cap_black <= black_sel;
            cap_gain  <= gain_clamped;
        end
    end

    // Delay the pulse so the later stages switch as the first new pixel reaches them.
    generate
        for (genvar d = 1; d <= 2; d++) begin : g_fs_delay
            always_ff @(posedge clk) begin
                if (!rst_n)
                    fs_d[d] <= 1'b0;
                else
                    fs_d[d] <= (d == 1) ? frame_start : fs_d[(d == 1) ? 1 : d-1];
            end
        end
    endgenerate

    // Hand the black level to stage 2 one clock after capture.
    always_ff @(posedge clk) begin
        if (!rst_n)
            black_s2 <= BLACK_DEF;
        else if (fs_d[1])
            black_s2 <= cap_black;
    end

    // Hand the gain to stage 3 two clocks after capture.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gain_s3 <= GAIN_ONE;
        else if (fs_d[2])
            gain_s3 <= cap_gain;
    end

    // Captured settings hold still unless a frame-start was seen.
    p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(frame_start)) |-> ($stable(knee_s1) && $stable(cap_gain) && $stable(cap_black)));

    // The gain reaching the multiplier is never below unity.
    p_gain_min_r7: assert property (@(posedge clk) disable iff (!rst_n)
        gain_s3 >= GAIN_ONE);

    // Stage-3 gain changes only two clocks after a frame-start.
    p_gain_stage_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(fs_d[2])) |-> $stable(gain_s3));
endmodule

// File: rtl/pdg_deknee.sv
// Stage 1: inverse knee. Samples above the knee are restored by doubling
// their distance from the knee. One output bit wider than the input.
// Assumes: the knee is held steady by the configuration stage.
module pdg_deknee #(
    parameter int PIX_W = pdg_pkg::PDG_PIX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [PIX_W-1:0] in_pix,
    input  logic [PIX_W-1:0] knee,
    output logic             out_valid,
    output logic [PIX_W:0]   out_x
);
    localparam int XW = PIX_W + 1;

    logic [XW-1:0] expanded;

    // Choose straight-through or expanded value.
    always_comb begin
        if (in_pix > knee)
            expanded = {in_pix, 1'b0} - XW'(knee);
        else
            expanded = XW'(in_pix);
    end

    // Register the stage output and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_x     <= '0;
        end else begin
            out_valid <= in_valid;
            out_x     <= expanded;
        end
    end

    // The inverse knee never lowers a sample and at most doubles it.
    p_deknee_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((out_x >= XW'($past(in_pix))) && (out_x <= {$past(in_pix), 1'b0})));
endmodule

// File: rtl/pdg_black_sub.sv
// Stage 2: black-level subtraction with a floor at zero.
// Assumes: black arrives from the configuration stage on its own schedule.
module pdg_black_sub #(
    parameter int PIX_W = pdg_pkg::PDG_PIX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [PIX_W:0]   in_x,
    input  logic [PIX_W-1:0] black,
    output logic             out_valid,
    output logic [PIX_W:0]   out_y
);
    localparam int XW = PIX_W + 1;

    logic [XW-1:0] black_ext;
    logic [XW-1:0] diff;

    // Subtract the pedestal, flooring at zero instead of wrapping.
    always_comb begin
        black_ext = XW'(black);
        diff      = (in_x >= black_ext) ? (in_x - black_ext) : '0;
    end

    // Register the stage output and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_y     <= '0;
        end else begin
            out_valid <= in_valid;
            out_y     <= diff;
        end
    end

    // Subtraction never raises a sample (no wraparound to large codes).
    p_black_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_y <= $past(in_x)));
endmodule

// File: rtl/pdg_gain.sv
// Stage 3: unsigned fixed-point gain, truncation of the fraction,
// saturation at full scale.
// Assumes: gain is already clamped to at least unity.
module pdg_gain #(
    parameter int PIX_W     = pdg_pkg::PDG_PIX_W,
    parameter int GAIN_W    = pdg_pkg::PDG_GAIN_W,
    parameter int GAIN_FRAC = pdg_pkg::PDG_GAIN_FRAC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [PIX_W:0]    in_y,
    input  logic [GAIN_W-1:0] gain,
    output logic              out_valid,
    output logic [PIX_W-1:0]  out_pix
);
    localparam int PROD_W = PIX_W + 1 + GAIN_W;
    localparam logic [PROD_W-1:0] FULL_P = PROD_W'((1 << PIX_W) - 1);
    localparam logic [PIX_W-1:0]  FULL   = '1;

    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] scaled;
    logic [PIX_W-1:0]  clipped;

    // Multiply, drop the fraction, saturate.
    always_comb begin
        prod    = PROD_W'(in_y) * PROD_W'(gain);
        scaled  = prod >> GAIN_FRAC;
        clipped = (scaled > FULL_P) ? FULL : scaled[PIX_W-1:0];
    end

    // Register the final sample and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_pix   <= '0;
        end else begin
            out_valid <= in_valid;
            out_pix   <= clipped;
        end
    end

    // With gain of at least 1.0 the output never falls below the clipped input.
    p_gain_unity_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((PIX_W+1)'(out_pix) >= (($past(in_y) > (PIX_W+1)'(FULL)) ? (PIX_W+1)'(FULL) : $past(in_y))));
endmodule

// File: rtl/pix_deknee_gain.sv
// Top of the pixel de-knee and gain stage: configuration capture and a
// three-stage pipeline (inverse knee, black subtraction, gain and clip).
// Assumes: one sample per clock at most; no back-pressure.
module pix_deknee_gain #(
    parameter int PIX_W     = pdg_pkg::PDG_PIX_W,
    parameter int GAIN_W    = pdg_pkg::PDG_GAIN_W,
    parameter int GAIN_FRAC = pdg_pkg::PDG_GAIN_FRAC,
    parameter int BLACK_NOM = pdg_pkg::PDG_BLACK_NOM
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic [PIX_W-1:0]  cfg_knee,
    input  logic [GAIN_W-1:0] cfg_gain,
    input  logic              cfg_black_ovr,
    input  logic [PIX_W-1:0]  cfg_black,
    input  logic              in_valid,
    input  logic [PIX_W-1:0]  in_pix,
    output logic              out_valid,
    output logic [PIX_W-1:0]  out_pix
);
    localparam int LAT = pdg_pkg::PDG_LATENCY;

    logic [PIX_W-1:0]  knee_s1;
    logic [PIX_W-1:0]  black_s2;
    logic [GAIN_W-1:0] gain_s3;
    logic              v1, v2;
    logic [PIX_W:0]    x1, y2;

    pdg_cfg_stage #(
        .PIX_W(PIX_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC), .BLACK_NOM(BLACK_NOM)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .cfg_knee(cfg_knee), .cfg_gain(cfg_gain),
        .cfg_black_ovr(cfg_black_ovr), .cfg_black(cfg_black),
        .knee_s1(knee_s1), .black_s2(black_s2), .gain_s3(gain_s3)
    );

    pdg_deknee #(.PIX_W(PIX_W)) u_deknee (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
        .knee(knee_s1), .out_valid(v1), .out_x(x1)
    );

    pdg_black_sub #(.PIX_W(PIX_W)) u_black (
        .clk(clk), .rst_n(rst_n), .in_valid(v1), .in_x(x1),
        .black(black_s2), .out_valid(v2), .out_y(y2)
    );

    pdg_gain #(.PIX_W(PIX_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC)) u_gain (
        .clk(clk), .rst_n(rst_n), .in_valid(v2), .in_y(y2),
        .gain(gain_s3), .out_valid(out_valid), .out_pix(out_pix)
    );

    // Count clocks since reset (saturating) so the latency check looks back only over clean history.
    logic [1:0] warm;
    always_ff @(posedge clk) begin
        if (!rst_n)
            warm <= '0;
        else if (warm != 2'(LAT))
            warm <= warm + 2'd1;
    end

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'(LAT)) |-> (out_valid == $past(in_valid, 3)));

    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(!rst_n) |-> (!out_valid && out_pix == '0));
endmodule

// File: tb/test_pix_deknee_gain.sv
// Self-checking bench: table of configuration/sample/expected vectors, then directed tests.
module test_pix_deknee_gain;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_start = 1'b0;
    logic [9:0] cfg_knee = 10'd1023;
    logic [7:0] cfg_gain = 8'h10;
    logic       cfg_black_ovr = 1'b0;
    logic [9:0] cfg_black = 10'd0;
    logic       in_valid = 1'b0;
    logic [9:0] in_pix = 10'd0;
    logic       out_valid;
    logic [9:0] out_pix;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    pix_deknee_gain i_pix_deknee_gain (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .cfg_knee(cfg_knee), .cfg_gain(cfg_gain),
        .cfg_black_ovr(cfg_black_ovr), .cfg_black(cfg_black),
        .in_valid(in_valid), .in_pix(in_pix),
        .out_valid(out_valid), .out_pix(out_pix)
    );

    // {tag, knee, gain, ovr, black, pixel, expected}
    localparam int NV = 18;
    localparam logic [52:0] VEC [NV] = '{
        {4'd4, 10'd1023, 8'h10, 1'b0, 10'd0,   10'd500,  10'd452},  // R4 default black
        {4'd3, 10'd400,  8'h10, 1'b0, 10'd0,   10'd500,  10'd552},  // R3 expand: 600-48
        {4'd3, 10'd400,  8'h10, 1'b0, 10'd0,   10'd400,  10'd352},  // R3 at knee
        {4'd3, 10'd400,  8'h10, 1'b0, 10'd0,   10'd401,  10'd354},  // R3 one above
        {4'd6, 10'd1023, 8'h20, 1'b0, 10'd0,   10'd300,  10'd504},  // R6 x2
        {4'd6, 10'd1023, 8'h18, 1'b0, 10'd0,   10'd148,  10'd150},  // R6 x1.5
        {4'd6, 10'd1023, 8'h13, 1'b0, 10'd0,   10'd65,   10'd20},   // R6 truncation
        {4'd5, 10'd1023, 8'h10, 1'b1, 10'd0,   10'd7,    10'd7},    // R5 black 0
        {4'd5, 10'd1023, 8'h20, 1'b1, 10'd10,  10'd60,   10'd100},  // R5 black 10
        {4'd8, 10'd1023, 8'h10, 1'b1, 10'd100, 10'd90,   10'd0},    // R8 below override
        {4'd8, 10'd1023, 8'h10, 1'b0, 10'd0,   10'd30,   10'd0},    // R8 below nominal
        {4'd8, 10'd1023, 8'h10, 1'b0, 10'd0,   10'd49,   10'd1},    // R8 edge
        {4'd7, 10'd1023, 8'h05, 1'b0, 10'd0,   10'd300,  10'd252},  // R7 sub-unity
        {4'd7, 10'd1023, 8'h00, 1'b0, 10'd0,   10'd100,  10'd52},   // R7 zero gain
        {4'd9, 10'd1023, 8'hFF, 1'b0, 10'd0,   10'd200,  10'd1023}, // R9 gain overflow
        {4'd9, 10'd0,    8'h10, 1'b0, 10'd0,   10'd1023, 10'd1023}, // R9 knee overflow
        {4'd9, 10'd100,  8'h10, 1'b1, 10'd0,   10'd600,  10'd1023}, // R9 knee overflow
        {4'd3, 10'd700,  8'h10, 1'b1, 10'd0,   10'd800,  10'd900}   // R3 high knee
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic load_cfg(input logic [9:0] k, input logic [7:0] g,
                            input logic o, input logic [9:0] b);
        @(negedge clk);
        cfg_knee = k; cfg_gain = g; cfg_black_ovr = o; cfg_black = b;
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    // Send one sample and sample the output three clocks later.
    task automatic send_one(input logic [9:0] p, output int res, output logic vld);
        in_valid = 1'b1; in_pix = p;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        res = int'(out_pix); vld = out_valid;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int r;
        logic v;
        repeat (4) @(negedge clk);
        // R1: outputs quiet during reset
        check("R1 valid in reset", int'(out_valid), 0);
        check("R1 data in reset", int'(out_pix), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", int'(out_valid), 0);
        // R1: reset settings (knee 1023, black 48, gain 1.0) without any frame-start
        cfg_knee = 10'd0; cfg_gain = 8'h40;
        send_one(10'd500, r, v);
        check("R1 default settings", r, 452);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            logic [52:0] e;
            string tag;
            e = VEC[i];
            load_cfg(e[48:39], e[38:31], e[30], e[29:20]);
            send_one(e[19:10], r, v);
            tag = $sformatf("R%0d vector %0d", int'(e[52:49]), i);
            check(tag, r, int'(e[9:0]));
            check("R2 valid with vector", int'(v), 1);
        end

        // R2: exact latency of a single sample
        load_cfg(10'd1023, 8'h10, 1'b1, 10'd0);
        in_valid = 1'b1; in_pix = 10'd77;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check("R2 not early", int'(out_valid), 0);
        @(negedge clk);
        check("R2 valid at 3", int'(out_valid), 1);
        check("R2 data at 3", int'(out_pix), 77);
        @(negedge clk);
        check("R2 single pulse", int'(out_valid), 0);

        // R10: cfg changes without frame-start are ignored
        cfg_gain = 8'h30; cfg_knee = 10'd0; cfg_black_ovr = 1'b0;
        send_one(10'd200, r, v);
        check("R10 cfg ignored", r, 200);

        // R11: sample in the frame-start cycle uses old settings; next uses new
        load_cfg(10'd1023, 8'h10, 1'b0, 10'd0);
        @(negedge clk);
        cfg_gain = 8'h20; cfg_black_ovr = 1'b1; cfg_black = 10'd0;
        frame_start = 1'b1; in_valid = 1'b1; in_pix = 10'd300;
        @(negedge clk);
        frame_start = 1'b0; in_valid = 1'b1; in_pix = 10'd300;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check("R11 old settings", int'(out_pix), 252);
        @(negedge clk);
        check("R11 new settings", int'(out_pix), 600);
        check("R11 second valid", int'(out_valid), 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule